// File: doc/BRIEF.md
# Serial Byte Receiver with Stop-Bit Check

This block turns an asynchronous serial line into bytes. The frame format is fixed: a low start bit, eight data bits with the least significant bit first, one high stop bit, and no parity. The line passes through a two-stage synchronizer. A falling edge is then confirmed at half a bit period, and each later bit is sampled once per bit period, so every sample falls near the middle of its bit. The bit period in clock cycles is set when the block is built, as the clock frequency divided by the baud rate. The default of 868 gives 115200 baud from a 100 MHz clock.

When the stop bit is high, the block shows the byte on its data output and raises a valid strobe for one cycle. When the stop bit is low, the byte is discarded. The block then raises a separate one-cycle error strobe and waits for the line to return high before it looks for another start bit. A consumer that reacts to the two strobes needs no other handshake.

Top module: `rx_framer`

## Requirements
- R1: While reset is held, and in the cycle after it is released with the line idle high, `dataValid` and `frameErr` are low.
- R2: `rxIn` passes through two flip-flops. With `rxIn` driven low just after clock edge 0, the strobe for that frame becomes visible after edge 3 + CLKS_PER_BIT/2 + 9*CLKS_PER_BIT.
- R3: Data bits arrive least significant bit first. When a frame's stop bit samples high, `rxByte` holds the eight data bits in that order while `dataValid` is high.
- R4: `dataValid` stays high for exactly one cycle per accepted frame, and `rxByte` changes only in a cycle where `dataValid` is high.
- R5: When the stop bit samples low, `frameErr` is high for exactly one cycle and `dataValid` does not rise for that frame.
- R6: A low pulse on the line that has ended by the half-bit point does not count as a start bit, and neither strobe rises.
- R7: Each bit is sampled once, a whole number of bit periods after the confirmed middle of the start bit. Line values that differ from the bit value only in the first two or the last cycle of a bit do not change the byte.
- R8: After a framing error the block does not arm again until the line has been high. A line held low after the error produces no further strobes.
- R9: A new frame whose start bit begins right after the previous stop bit is received correctly.
- R10: `dataValid` and `frameErr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Asynchronous serial line, idle high |
| rxByte | output | DATA_BITS | Last accepted byte |
| dataValid | output | 1 | One-cycle strobe for an accepted byte |
| frameErr | output | 1 | One-cycle strobe for a frame with a low stop bit |

## Verification
The bench uses a short bit period and sends all 256 byte values back to back. On half of those frames it inverts the line near each data-bit boundary. A receiver that samples at the edge of a bit, or that counts bits from the falling edge instead of the mid-start point, gives wrong bytes there. The bench also checks the exact strobe latency, so a missing or extra synchronizer stage shows up as an off-by-one. Frames with a low stop bit must give only an error pulse. The bench sends one of these followed by a long low line: a receiver that re-arms without waiting for the line to go high keeps producing errors. Short low glitches of every length up to half a bit must leave no trace. A receiver that acts on the raw edge instead of confirming it at half a bit would report a frame for them.

// File: rtl/rx_framer_pkg.sv
package rx_framer_pkg;

  typedef struct packed {
    logic cntClear;
    logic bitClear;
    logic shiftBit;
    logic deliver;
    logic flagErr;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rxState_t;

endpackage

// File: rtl/rx_framer_dp.sv
module rx_framer_dp
  import rx_framer_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  ctlStrobes_t          ctl,
  output logic                 lineNow,
  output logic                 halfHit,
  output logic                 fullHit,
  output logic                 lastBit,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 dataValid,
  output logic                 frameErr
);

  localparam int HALF  = CLKS_PER_BIT / 2;
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
  localparam int IDX_W = $clog2(DATA_BITS + 1);

  logic                 syncA, syncB;
  logic [CNT_W-1:0]     cycleCnt;
  logic [IDX_W-1:0]     bitIdx;
  logic [DATA_BITS-1:0] shiftReg;

  // two-stage synchronizer, reset to idle-high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= rxIn;
      syncB <= syncA;
    end
  end
  assign lineNow = syncB;

  // bit-period timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cycleCnt <= '0;
    else if (ctl.cntClear) cycleCnt <= '0;
    else                   cycleCnt <= cycleCnt + 1'b1;
  end
  assign halfHit = (cycleCnt == CNT_W'(HALF - 1));
  assign fullHit = (cycleCnt == CNT_W'(CLKS_PER_BIT - 1));

  // bit index and LSB-first shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= '0;
      shiftReg <= '0;
    end else if (ctl.bitClear) begin
      bitIdx   <= '0;
    end else if (ctl.shiftBit) begin
      bitIdx   <= bitIdx + 1'b1;
      shiftReg <= {lineNow, shiftReg[DATA_BITS-1:1]};
    end
  end
  assign lastBit = (bitIdx == IDX_W'(DATA_BITS - 1));

  // output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      dataValid <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      dataValid <= ctl.deliver;
      frameErr  <= ctl.flagErr;
      if (ctl.deliver) rxByte <= shiftReg;
    end
  end

  // R3
  deliver_needs_high_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.deliver |-> lineNow);

  // R5
  error_needs_low_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagErr |-> !lineNow);

  // R4
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R4
  byte_changes_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxByte) |-> dataValid);

  // R5
  error_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataValid, frameErr}));

endmodule

// File: rtl/rx_framer_ctl.sv
module rx_framer_ctl
  import rx_framer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineNow,
  input  logic        halfHit,
  input  logic        fullHit,
  input  logic        lastBit,
  output ctlStrobes_t ctl
);

  rxState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (!lineNow) begin
          ctl.cntClear = 1'b1;
          stateNext    = ST_START;
        end
      end
      ST_START: begin
        if (halfHit) begin
          if (!lineNow) begin
            ctl.cntClear = 1'b1;
            ctl.bitClear = 1'b1;
            stateNext    = ST_DATA;
          end else begin
            stateNext    = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (fullHit) begin
          ctl.cntClear = 1'b1;
          ctl.shiftBit = 1'b1;
          if (lastBit) stateNext = ST_STOP;
        end
      end
      ST_STOP: begin
        if (fullHit) begin
          if (lineNow) begin
            ctl.deliver = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            ctl.flagErr = 1'b1;
            stateNext   = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (lineNow) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R8
  hold_until_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !lineNow) |=> (state == ST_HOLD));

  // R6
  glitch_returns_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && halfHit && lineNow) |=> (state == ST_IDLE));

endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_framer_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 dataValid,
  output logic                 frameErr
);

  ctlStrobes_t ctl;
  logic        lineNow, halfHit, fullHit, lastBit;

  rx_framer_dp #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .ctl       (ctl),
    .lineNow   (lineNow),
    .halfHit   (halfHit),
    .fullHit   (fullHit),
    .lastBit   (lastBit),
    .rxByte    (rxByte),
    .dataValid (dataValid),
    .frameErr  (frameErr)
  );

  rx_framer_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .lineNow (lineNow),
    .halfHit (halfHit),
    .fullHit (fullHit),
    .lastBit (lastBit),
    .ctl     (ctl)
  );

endmodule

// File: tb/rx_framer_bench.sv
module rx_framer_bench;

  localparam int C     = 8;
  localparam int HALF  = C / 2;
  localparam int LAT   = 3 + HALF + 9 * C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic [7:0] rxByte;
  logic       dataValid, frameErr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int vPulses = 0, ePulses = 0, vWide = 0, eWide = 0;
  int lastVCyc = 0, lastECyc = 0;
  logic [7:0] lastByte = '0;
  logic prevV = 1'b0, prevE = 1'b0;
  int startCyc = 0;

  rx_framer #(.CLKS_PER_BIT(C), .DATA_BITS(8)) u_rx_framer (
    .clk(clk), .rstN(rstN), .rxIn(rxIn),
    .rxByte(rxByte), .dataValid(dataValid), .frameErr(frameErr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (dataValid) begin
        vPulses++; lastByte = rxByte; lastVCyc = cyc;
        if (prevV) vWide++;
      end
      if (frameErr) begin
        ePulses++; lastECyc = cyc;
        if (prevE) eWide++;
      end
      prevV = dataValid;
      prevE = frameErr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic holdLine(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      rxIn = v;
      @(negedge clk);
    end
  endtask

  // send one frame starting at a negedge; corrupt inverts data bits near their edges
  task automatic sendFrame(input logic [7:0] b, input logic stopBit, input bit corrupt);
    startCyc = cyc;
    holdLine(1'b0, C);
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < C; i++) begin
        rxIn = (corrupt && (i < 2 || i == C - 1)) ? ~b[k] : b[k];
        @(negedge clk);
      end
    end
    holdLine(stopBit, C);
  endtask

  initial begin
    int v0, e0;
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v0, e0;
    repeat (4) @(negedge clk);
    // R1
    check(!dataValid && !frameErr, "R1 during reset", {dataValid, frameErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!dataValid && !frameErr, "R1 after reset", {dataValid, frameErr}, 0);
    holdLine(1'b1, 2 * C);

    // R3 R4 R7 R9: all byte values back to back, odd ones with edge corruption
    for (int b = 0; b < 256; b++) begin
      v0 = vPulses; e0 = ePulses;
      sendFrame(8'(b), 1'b1, (b % 2) == 1);
      check(vPulses - v0 == 1, "R9 one valid per frame", vPulses - v0, 1);
      check(lastByte == 8'(b), (b % 2) ? "R7 byte under edge noise" : "R3 byte LSB first",
            lastByte, b);
      check(ePulses == e0, "R10 no error on good frame", ePulses - e0, 0);
      check(lastVCyc - startCyc == LAT, "R2 valid latency", lastVCyc - startCyc, LAT);
    end
    holdLine(1'b1, C);
    check(vWide == 0, "R4 valid width one cycle", vWide, 0);

    // R5: low stop bits, line returns high at once
    for (int j = 0; j < 16; j++) begin
      v0 = vPulses; e0 = ePulses;
      sendFrame(8'(j * 17 + 3), 1'b0, 1'b0);
      holdLine(1'b1, 2 * C);
      check(ePulses - e0 == 1, "R5 one error pulse", ePulses - e0, 1);
      check(vPulses == v0, "R5 no valid on bad stop", vPulses - v0, 0);
      check(lastECyc - startCyc == LAT, "R2 error latency", lastECyc - startCyc, LAT);
    end
    check(eWide == 0, "R5 error width one cycle", eWide, 0);

    // R8: line stays low long after the error
    v0 = vPulses; e0 = ePulses;
    sendFrame(8'h00, 1'b0, 1'b0);
    holdLine(1'b0, 30 * C);
    holdLine(1'b1, 2 * C);
    check(ePulses - e0 == 1, "R8 single error while held low", ePulses - e0, 1);
    check(vPulses == v0, "R8 no valid while held low", vPulses - v0, 0);
    v0 = vPulses;
    sendFrame(8'hA5, 1'b1, 1'b0);
    holdLine(1'b1, C);
    check(vPulses - v0 == 1 && lastByte == 8'hA5, "R8 recovery byte", lastByte, 8'hA5);

    // R6: glitches of every length up to half a bit
    for (int g = 1; g <= HALF; g++) begin
      v0 = vPulses; e0 = ePulses;
      holdLine(1'b0, g);
      holdLine(1'b1, 12 * C);
      check(vPulses == v0 && ePulses == e0, "R6 glitch ignored",
            (vPulses - v0) + (ePulses - e0), 0);
    end
    v0 = vPulses;
    sendFrame(8'h3C, 1'b1, 1'b1);
    holdLine(1'b1, C);
    check(vPulses - v0 == 1 && lastByte == 8'h3C, "R6 frame after glitches", lastByte, 8'h3C);
    check(vWide == 0 && eWide == 0, "R10 strobes stayed single", vWide + eWide, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule